// File: doc/BRIEF.md
# Serial port status flags and interrupt requests

This block keeps the eight-bit status register and the eight-bit control register of an asynchronous serial port and produces the port's three interrupt request lines: transmit buffer empty, transmit complete and receive complete. The transmitter and the receiver tell it about events as one-cycle strobes: a byte moved from the buffer into the shifter, the last stop bit sent, a byte received with its error bits, and a received byte taken away. The CPU side writes the control register and the status register, issues a strobe for each write to the transmit buffer, and acknowledges interrupts per vector.

Each request line follows the AND of a flag and its enable bit. It is stored and changes state only on a cycle after that product has changed, so a request always lags the product by one clock. The transmit-complete flag clears itself when its interrupt is acknowledged, and can also be cleared by software writing a one to it. The receive error bits are stored here but generated by the receiver.

Top module: `uart_flag_irq`

## Requirements
- R1: During and right after a synchronous active-low reset, status reads 0x20 (buffer-empty flag at bit 5 set, all else clear), control reads 0x00 and all three request lines are low.
- R2: A control write loads all eight bits, visible on the next cycle; bit 5 enables the empty request, bit 6 the transmit-complete request, bit 7 the receive-complete request.
- R3: A status write loads only bits 1:0 (multiprocessor mode, double speed); a one in bit 6 clears the transmit-complete flag, a zero there leaves it alone, and bits 2, 3, 4, 5 and 7 are never changed by a status write.
- R4: irq[0] (empty), irq[1] (transmit complete) and irq[2] (receive complete) equal, one cycle later, the AND of status bit 5, 6, 7 with control bit 5, 6, 7 respectively; a line only changes after its product has changed.
- R5: A data-register write strobe clears the empty flag (bit 5); a transmitter load strobe sets it; when both occur in one cycle the flag ends clear.
- R6: A transmit-done strobe sets the transmit-complete flag (bit 6); a transmitter load strobe clears it and wins over a transmit-done strobe in the same cycle.
- R7: Acknowledging vector 1 (irq_ack[1]) clears the transmit-complete flag unless transmit-done occurs in the same cycle; acknowledging vectors 0 and 2 changes no status bit.
- R8: A receive-done strobe sets the receive-complete flag (bit 7) and loads rx_err into bits 4:2 (bit 2 parity, bit 3 overrun, bit 4 framing); a receive-clear strobe clears bit 7, and receive-done wins when both occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stat_wr | input | 1 | CPU write strobe for the status register |
| ctrl_wr | input | 1 | CPU write strobe for the control register |
| wr_data | input | 8 | CPU write data for either register |
| data_wr | input | 1 | CPU write to the transmit data register |
| tx_load | input | 1 | Transmitter took the buffered byte into its shifter |
| tx_done | input | 1 | Transmitter finished a frame with nothing queued |
| rx_done | input | 1 | Receiver completed a byte |
| rx_clr | input | 1 | Received byte taken away |
| rx_err | input | 3 | Error bits of the received byte, captured on rx_done |
| irq_ack | input | 3 | Interrupt acknowledge per vector |
| status | output | 8 | Status register |
| control | output | 8 | Control register |
| irq | output | 3 | Interrupt requests: empty, transmit complete, receive complete |

## Verification
The assertions take every event and write input to be a single-cycle strobe sampled on the rising edge, rx_err to matter only in a cycle with rx_done, and reset to be held low from time zero until a few edges have passed. The stimulus changes inputs one time unit after an edge and clears every strobe after the edge that consumes it, so no strobe is held across two cycles. Conflicting strobes are combined on purpose in single cycles to hit each priority rule, and all enable and flag combinations are swept for the request lines.

// File: rtl/uart_flag_pkg.sv
// Package: uart_flag_pkg
// Register widths and bit positions shared by the flag and interrupt logic.
// Assumes an eight-bit register file; positions are fixed by the CPU view.
package uart_flag_pkg;
    localparam int REG_W    = 8;
    localparam int ERR_W    = 3;
    localparam int NUM_IRQ  = 3;

    // status bit positions
    localparam int ST_MPM   = 0;
    localparam int ST_DSPD  = 1;
    localparam int ST_ERR0  = 2;
    localparam int ST_EMPTY = 5;
    localparam int ST_TXC   = 6;
    localparam int ST_RXC   = 7;

    // first flag bit that has a request line; flag n+IRQ_BASE pairs with enable n+IRQ_BASE
    localparam int IRQ_BASE = ST_EMPTY;

    localparam logic [REG_W-1:0] STATUS_RST  = REG_W'(1) << ST_EMPTY;
    localparam logic [REG_W-1:0] CONTROL_RST = '0;
endpackage

// File: rtl/ufi_status_reg.sv
// Module: ufi_status_reg
// Holds the status register. Each flag has its own set and clear sources
// with a fixed priority. Assumes all event inputs are one-cycle strobes.
module ufi_status_reg
    import uart_flag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic [REG_W-1:0] cpu_wdata,
    input  logic             data_wr,
    input  logic             tx_load,
    input  logic             tx_done,
    input  logic             txc_ack,
    input  logic             rx_done,
    input  logic             rx_clr,
    input  logic [ERR_W-1:0] rx_err,
    output logic [REG_W-1:0] status
);
    logic [REG_W-1:0] stat_q;
    logic [REG_W-1:0] stat_d;
    logic             txc_clear_req;

    // software write-one or interrupt acknowledge both ask to drop the TX-complete flag
    assign txc_clear_req = (cpu_wr && cpu_wdata[ST_TXC]) || txc_ack;

    // next-state of every status field
    always_comb begin
        stat_d = stat_q;
        if (cpu_wr) begin
            stat_d[ST_MPM]  = cpu_wdata[ST_MPM];
            stat_d[ST_DSPD] = cpu_wdata[ST_DSPD];
        end
        if (rx_done) begin
            stat_d[ST_ERR0 +: ERR_W] = rx_err;
        end
        if (data_wr) begin
            stat_d[ST_EMPTY] = 1'b0;
        end else if (tx_load) begin
            stat_d[ST_EMPTY] = 1'b1;
        end
        if (tx_load) begin
            stat_d[ST_TXC] = 1'b0;
        end else if (tx_done) begin
            stat_d[ST_TXC] = 1'b1;
        end else if (txc_clear_req) begin
            stat_d[ST_TXC] = 1'b0;
        end
        if (rx_done) begin
            stat_d[ST_RXC] = 1'b1;
        end else if (rx_clr) begin
            stat_d[ST_RXC] = 1'b0;
        end
    end

    // status register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= STATUS_RST;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign status = stat_q;
endmodule

// File: rtl/ufi_ctrl_reg.sv
// Module: ufi_ctrl_reg
// Holds the control register, loaded whole by a CPU write strobe.
// Assumes the write strobe lasts one cycle.
module ufi_ctrl_reg
    import uart_flag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] control
);
    logic [REG_W-1:0] ctrl_q;

    // control register load with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CONTROL_RST;
        end else if (cpu_wr) begin
            ctrl_q <= cpu_wdata;
        end
    end

    assign control = ctrl_q;
endmodule

// File: rtl/ufi_irq_edge.sv
// Module: ufi_irq_edge
// One interrupt request line. The flag-and-enable product is compared with
// the stored request; the request is raised on a rising product and dropped
// on a falling one, and otherwise held. Assumes flag and enable are registered.
module ufi_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    input  logic enable,
    output logic req
);
    logic prod;
    logic req_q;
    logic rise;
    logic fall;

    assign prod = flag && enable;
    assign rise = prod && !req_q;
    assign fall = !prod && req_q;

    // raise or drop the request only when the product changed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (rise) begin
            req_q <= 1'b1;
        end else if (fall) begin
            req_q <= 1'b0;
        end
    end

    assign req = req_q;
endmodule

// File: rtl/uart_flag_irq.sv
// Module: uart_flag_irq
// Status and control registers of a serial port plus its three interrupt
// request lines (buffer empty, transmit complete, receive complete).
// Assumes transmitter, receiver and CPU events arrive as one-cycle strobes.
module uart_flag_irq
    import uart_flag_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stat_wr,
    input  logic               ctrl_wr,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               data_wr,
    input  logic               tx_load,
    input  logic               tx_done,
    input  logic               rx_done,
    input  logic               rx_clr,
    input  logic [ERR_W-1:0]   rx_err,
    input  logic [NUM_IRQ-1:0] irq_ack,
    output logic [REG_W-1:0]   status,
    output logic [REG_W-1:0]   control,
    output logic [NUM_IRQ-1:0] irq
);
    localparam int TXC_VEC = ST_TXC - IRQ_BASE;

    logic [REG_W-1:0] stat_w;
    logic [REG_W-1:0] ctrl_w;
    logic [NUM_IRQ-1:0] unused_ack;

    // only the transmit-complete vector has a side effect on acknowledge
    assign unused_ack = irq_ack & ~(NUM_IRQ'(1) << TXC_VEC);

    ufi_status_reg i_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (stat_wr),
        .cpu_wdata (wr_data),
        .data_wr   (data_wr),
        .tx_load   (tx_load),
        .tx_done   (tx_done),
        .txc_ack   (irq_ack[TXC_VEC]),
        .rx_done   (rx_done),
        .rx_clr    (rx_clr),
        .rx_err    (rx_err),
        .status    (stat_w)
    );

    ufi_ctrl_reg i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (ctrl_wr),
        .cpu_wdata (wr_data),
        .control   (ctrl_w)
    );

    for (genvar v = 0; v < NUM_IRQ; v++) begin : g_irq
        ufi_irq_edge i_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .flag   (stat_w[IRQ_BASE + v]),
            .enable (ctrl_w[IRQ_BASE + v]),
            .req    (irq[v])
        );
    end

    assign status  = stat_w;
    assign control = ctrl_w;
endmodule

// File: rtl/uart_flag_irq_chk.sv
// Module: uart_flag_irq_chk
// Port-level properties of uart_flag_irq, attached through bind.
// Assumes reset is low from time zero.
module uart_flag_irq_chk
    import uart_flag_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stat_wr,
    input  logic               ctrl_wr,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               data_wr,
    input  logic               tx_load,
    input  logic               tx_done,
    input  logic               rx_done,
    input  logic               rx_clr,
    input  logic [ERR_W-1:0]   rx_err,
    input  logic [NUM_IRQ-1:0] irq_ack,
    input  logic [REG_W-1:0]   status,
    input  logic [REG_W-1:0]   control,
    input  logic [NUM_IRQ-1:0] irq
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status == STATUS_RST && control == CONTROL_RST && irq == '0));

    // R2
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> control == $past(wr_data));

    // R3
    txc_zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !wr_data[ST_TXC] && !tx_done && !tx_load && !irq_ack[1])
        |=> $stable(status[ST_TXC]));

    // R3
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !rx_done) |=> $stable(status[4:2]));

    // R4
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(rst_n) |-> irq == $past(status[7:5] & control[7:5]));

    // R5
    empty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> !status[ST_EMPTY]);

    // R6
    txc_load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !status[ST_TXC]);

    // R7
    txc_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack[1] && !tx_done) |=> !status[ST_TXC]);

    // R8
    rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> (status[ST_RXC] && status[4:2] == $past(rx_err)));

    // R8
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr && !rx_done) |=> !status[ST_RXC]);
endmodule

bind uart_flag_irq uart_flag_irq_chk i_uart_flag_irq_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_wr (stat_wr),
    .ctrl_wr (ctrl_wr),
    .wr_data (wr_data),
    .data_wr (data_wr),
    .tx_load (tx_load),
    .tx_done (tx_done),
    .rx_done (rx_done),
    .rx_clr  (rx_clr),
    .rx_err  (rx_err),
    .irq_ack (irq_ack),
    .status  (status),
    .control (control),
    .irq     (irq)
);

// File: tb/test_uart_flag_irq.sv
module test_uart_flag_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stat_wr = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       data_wr = 1'b0;
    logic       tx_load = 1'b0;
    logic       tx_done = 1'b0;
    logic       rx_done = 1'b0;
    logic       rx_clr = 1'b0;
    logic [2:0] rx_err = '0;
    logic [2:0] irq_ack = '0;
    logic [7:0] status;
    logic [7:0] control;
    logic [2:0] irq;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_s = 8'h20;
    logic [7:0] exp_c = 8'h00;
    logic [2:0] exp_irq = 3'b000;

    always #2 clk = ~clk;

    uart_flag_irq i_uart_flag_irq (
        .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .ctrl_wr(ctrl_wr),
        .wr_data(wr_data), .data_wr(data_wr), .tx_load(tx_load),
        .tx_done(tx_done), .rx_done(rx_done), .rx_clr(rx_clr),
        .rx_err(rx_err), .irq_ack(irq_ack), .status(status),
        .control(control), .irq(irq)
    );

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    // expected next state from the requirements; inputs are already driven
    task automatic step(string tag);
        logic [7:0] n;
        exp_irq = exp_s[7:5] & exp_c[7:5];             // R4: one-cycle lag
        n = exp_s;
        if (stat_wr) n[1:0] = wr_data[1:0];             // R3
        if (rx_done) n[4:2] = rx_err;                   // R8
        if (data_wr) n[5] = 1'b0;                       // R5
        else if (tx_load) n[5] = 1'b1;
        if (tx_load) n[6] = 1'b0;                       // R6
        else if (tx_done) n[6] = 1'b1;
        else if ((stat_wr && wr_data[6]) || irq_ack[1]) n[6] = 1'b0; // R3 R7
        if (rx_done) n[7] = 1'b1;                       // R8
        else if (rx_clr) n[7] = 1'b0;
        if (ctrl_wr) exp_c = wr_data;                   // R2
        exp_s = n;
        @(posedge clk);
        #1;
        check(tag, "status", status, exp_s);
        check(tag, "control", control, exp_c);
        check(tag, "irq", {5'b0, irq}, {5'b0, exp_irq});
        stat_wr = 0; ctrl_wr = 0; data_wr = 0; tx_load = 0; tx_done = 0;
        rx_done = 0; rx_clr = 0; irq_ack = '0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: state held by reset, then first cycle out of reset
        check("R1", "status", status, 8'h20);
        check("R1", "control", control, 8'h00);
        check("R1", "irq", {5'b0, irq}, 8'h00);
        rst_n = 1'b1;
        step("R1");

        // R2: every control value
        for (int v = 0; v < 256; v++) begin
            ctrl_wr = 1; wr_data = 8'(v);
            step("R2");
        end
        ctrl_wr = 1; wr_data = 8'h00; step("R2");

        // R3: every status write value, with TX-complete and errors set first
        for (int v = 0; v < 256; v++) begin
            tx_done = 1; rx_done = 1; rx_err = 3'(v); step("R8");
            stat_wr = 1; wr_data = 8'(v); step("R3");
        end

        // R4: every flag pattern against every enable pattern
        for (int e = 0; e < 8; e++) begin
            for (int p = 0; p < 8; p++) begin
                if (p[0]) tx_load = 1; else data_wr = 1;
                step("R5");
                if (p[1]) tx_done = 1; else irq_ack[1] = 1;
                step("R7");
                if (p[2]) rx_done = 1; else rx_clr = 1;
                step("R8");
                ctrl_wr = 1; wr_data = 8'(e << 5);
                step("R4");
                step("R4");
                step("R4");
            end
        end

        // R5: load and data write together leave empty clear
        tx_load = 1; step("R5");
        tx_load = 1; data_wr = 1; step("R5");
        // R6: load beats transmit-done
        tx_done = 1; step("R6");
        tx_load = 1; tx_done = 1; step("R6");
        // R7: done beats acknowledge; other vectors have no effect
        tx_done = 1; irq_ack[1] = 1; step("R7");
        irq_ack[0] = 1; step("R7");
        irq_ack[2] = 1; step("R7");
        irq_ack = 3'b101; step("R7");
        irq_ack[1] = 1; step("R7");
        // R8: receive-done beats receive-clear; every error pattern
        for (int r = 0; r < 8; r++) begin
            rx_done = 1; rx_clr = 1; rx_err = 3'(r); step("R8");
            rx_clr = 1; step("R8");
        end
        // R4: request drops when the enable goes away
        tx_load = 1; step("R4");
        ctrl_wr = 1; wr_data = 8'h20; step("R4");
        step("R4");
        ctrl_wr = 1; wr_data = 8'h00; step("R4");
        step("R4");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule